// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is a synthesizable behavioural model of the command side of a parallel boot-block flash device. A host drives byte-wide bus writes through an active-low chip enable and an active-low write strobe. Each write is captured when the first of those two signals returns high. The controller decodes the written codes into single-cycle commands (read array, read status, read identifier, clear status) and into two-cycle sequences (program, block erase, full-chip erase). It then runs the chosen operation internally for a parameterised number of clock cycles. The storage is a small register memory that can be inferred as block RAM.

While an operation runs, `ready` is low and every read returns the status byte. A host driver polls status bit 7 until it reads 1. An erase can be suspended during its timed phase so that the host can read or program other blocks. A program can be suspended as well. Both resume with the same confirm code. A bad confirm code after an erase setup sets the two error flags in the status byte, and those flags remain set until the host clears them.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `ready` is 1 and reads return array data. Every array location reads 0xFF. Once code 0x70 is written, the status byte reads 0x80.
- R2: Writing 0x40 or 0x10 and then a second write carrying address and data starts a program of that location. The operation stays busy for PROG_CYC cycles and then returns to ready.
- R3: A program stores the old byte ANDed with the written byte, so it can only clear bits.
- R4: While an operation runs, `ready` is 0 and status bit 7 reads 0. Reads return the status byte whatever read mode was selected. Every command other than 0xB0 is ignored.
- R5: Writing 0x20 and then 0xD0 erases the block selected by address bits [AW-1:BLK_AW] to 0xFF. Other blocks keep their contents.
- R6: Writing 0x30 and then 0xD0 erases every location to 0xFF.
- R7: When an erase setup (0x20 or 0x30) is followed by any code other than 0xD0, status bits 5 and 4 are set. The controller stays ready and the array is unchanged.
- R8: Error bits persist across later commands until code 0x50 clears status bits 5, 4, 3 and 1.
- R9: Code 0xFF selects array reads. Code 0x70 selects status reads, which persist until another command arrives. Code 0x90 selects identifier reads: an even address returns MFR_ID (default 0x5A) and an odd address returns DEV_ID (default 0xC3).
- R10: Code 0xB0 during the timed phase of an erase makes the controller ready and sets status bit 6, with the erasing block unchanged. While the erase is suspended, only 0xFF, 0x70, program and 0xD0 are accepted, so a 0x20 is ignored. A program during the suspend completes normally.
- R11: Code 0xD0 written during an erase suspend clears status bits 7 and 6 and lowers `ready`. The erase then completes.
- R12: Code 0xB0 during a program makes the controller ready and sets status bit 2 while the target location stays unchanged. Code 0xD0 resumes the program, which completes.
- R13: Address and data are captured while both strobes are low. A change of `din` after one strobe has risen has no effect on the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | AW | Byte address |
| din | input | DW | Write data or command code |
| dout | output | DW | Read data, valid one cycle after `addr` |
| ready | output | 1 | 1 when no internal operation is running |

## Verification
The hardest state to reach is a program nested inside a suspended erase. The erase must be caught in its timed phase, before the block sweep starts. The program issued during the suspend must finish without disturbing the suspended erase. The erase must then resume and wipe only its own block. The stimulus sets a long erase time and writes 0xB0 within a few cycles of the erase confirm. It then probes with a 0x20 followed by 0x70: if the 0x20 were wrongly accepted, the 0x70 would act as a bad confirm and show up as error bits. A strobe order with the chip enable rising first, and data changing afterwards, checks the capture rule.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT} rmode_t;
  typedef enum logic [1:0] {SU_NONE, SU_BLK, SU_CHIP, SU_PROG} setup_t;

  localparam logic [7:0] OP_READ    = 8'hFF;
  localparam logic [7:0] OP_STAT    = 8'h70;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_CLR     = 8'h50;
  localparam logic [7:0] OP_BERASE  = 8'h20;
  localparam logic [7:0] OP_CERASE  = 8'h30;
  localparam logic [7:0] OP_PROG_A  = 8'h40;
  localparam logic [7:0] OP_PROG_B  = 8'h10;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;
endpackage

// File: rtl/bus_capture.sv
module bus_capture #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_vld,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic act, act_q;
  assign act = !we_n && !ce_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      act_q <= act;
      if (act) begin
        wr_addr <= addr;
        wr_data <= din;
      end
    end
  end

  // first strobe to rise ends the write; the values latched last stay
  assign wr_vld = act_q && !act;

  // R13
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_vld |=> !wr_vld);
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] int_addr,
  output logic [DW-1:0] int_data,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_data  <= mem[rd_addr];
    int_data <= mem[int_addr];
  end
endmodule

// File: rtl/wsm_ctrl.sv
module wsm_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW        = 6,
  parameter int DW        = 8,
  parameter int BLK_AW    = 4,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_vld,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] int_data,
  output logic [AW-1:0] int_addr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output rmode_t        rmode_o,
  output logic [7:0]    status_o,
  output logic          ready_o
);
  localparam int TMAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_ONE = TW'(1);

  setup_t        setup;
  rmode_t        rmode;
  logic          p_active, psusp;
  logic [TW-1:0] p_tmr;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;
  logic          e_active, esusp, e_sweep;
  logic [TW-1:0] e_tmr;
  logic [AW-1:0] sw_ptr, e_hi;
  logic          err_e, err_p, ready_q;

  logic running_prog, running_erase, running, prog_done, sweep_we;
  assign running_prog  = p_active && !psusp;
  assign running_erase = e_active && !esusp && !running_prog;
  assign running       = running_prog || running_erase;
  assign prog_done     = running_prog && (p_tmr == T_ONE);
  assign sweep_we      = running_erase && e_sweep;

  assign int_addr  = p_addr;
  assign mem_we    = prog_done || sweep_we;
  assign mem_waddr = prog_done ? p_addr : sw_ptr;
  assign mem_wdata = prog_done ? (int_data & p_data) : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      setup    <= SU_NONE;
      rmode    <= RM_ARRAY;
      p_active <= 1'b0;
      psusp    <= 1'b0;
      p_tmr    <= '0;
      p_addr   <= '0;
      p_data   <= '0;
      e_active <= 1'b0;
      esusp    <= 1'b0;
      e_sweep  <= 1'b0;
      e_tmr    <= '0;
      sw_ptr   <= '0;
      e_hi     <= '0;
      err_e    <= 1'b0;
      err_p    <= 1'b0;
      ready_q  <= 1'b1;
    end else begin
      ready_q <= !running;

      if (running_prog) begin
        if (p_tmr == T_ONE) p_active <= 1'b0;
        else                p_tmr    <= p_tmr - T_ONE;
      end
      if (running_erase) begin
        if (!e_sweep) begin
          if (e_tmr == T_ONE) e_sweep <= 1'b1;
          else                e_tmr   <= e_tmr - T_ONE;
        end else if (sw_ptr == e_hi) begin
          e_active <= 1'b0;
        end else begin
          sw_ptr <= sw_ptr + 1'b1;
        end
      end

      if (wr_vld) begin
        if (running) begin
          if (wr_data == OP_SUSPEND) begin
            rmode <= RM_STATUS;
            if (running_prog) begin
              if (p_tmr != T_ONE) psusp <= 1'b1;
            end else if (!e_sweep && e_tmr != T_ONE) begin
              esusp <= 1'b1;
            end
          end
        end else if (setup == SU_PROG) begin
          p_active <= 1'b1;
          p_tmr    <= TW'(PROG_CYC);
          p_addr   <= wr_addr;
          p_data   <= wr_data;
          setup    <= SU_NONE;
          rmode    <= RM_STATUS;
        end else if (setup != SU_NONE) begin
          setup <= SU_NONE;
          rmode <= RM_STATUS;
          if (wr_data == OP_CONFIRM) begin
            e_active <= 1'b1;
            e_tmr    <= TW'(ERASE_CYC);
            e_sweep  <= 1'b0;
            if (setup == SU_CHIP) begin
              sw_ptr <= '0;
              e_hi   <= '1;
            end else begin
              sw_ptr <= {wr_addr[AW-1:BLK_AW], {BLK_AW{1'b0}}};
              e_hi   <= {wr_addr[AW-1:BLK_AW], {BLK_AW{1'b1}}};
            end
          end else begin
            err_e <= 1'b1;
            err_p <= 1'b1;
          end
        end else begin
          case (wr_data)
            OP_READ:  rmode <= RM_ARRAY;
            OP_STAT:  rmode <= RM_STATUS;
            OP_IDENT: if (!esusp && !psusp) rmode <= RM_IDENT;
            OP_CLR: if (!esusp && !psusp) begin
              err_e <= 1'b0;
              err_p <= 1'b0;
            end
            OP_BERASE: if (!e_active && !p_active) begin
              setup <= SU_BLK;
              rmode <= RM_STATUS;
            end
            OP_CERASE: if (!e_active && !p_active) begin
              setup <= SU_CHIP;
              rmode <= RM_STATUS;
            end
            OP_PROG_A, OP_PROG_B: if (!p_active) begin
              setup <= SU_PROG;
              rmode <= RM_STATUS;
            end
            OP_CONFIRM: begin
              if (psusp) begin
                psusp <= 1'b0;
                rmode <= RM_STATUS;
              end else if (esusp) begin
                esusp <= 1'b0;
                rmode <= RM_STATUS;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign rmode_o  = running ? RM_STATUS : rmode;
  assign status_o = {ready_q, esusp, err_e, err_p, 1'b0, psusp, 2'b00};
  assign ready_o  = ready_q;

  // R12
  psusp_owner_chk: assert property (@(posedge clk) disable iff (rst)
    psusp |-> p_active);

  // R10
  esusp_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (esusp && $past(esusp)) |-> $stable(e_tmr));

  // R7
  err_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_e) |-> $past(wr_vld));

  // R3
  prog_clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    prog_done |-> ((mem_wdata & ~int_data) == '0));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW        = 6,
  parameter int DW        = 8,
  parameter int BLK_AW    = 4,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40,
  parameter logic [DW-1:0] MFR_ID = 8'h5A,
  parameter logic [DW-1:0] DEV_ID = 8'hC3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          ready
);
  logic          wr_vld;
  logic [AW-1:0] wr_addr, int_addr, mem_waddr;
  logic [DW-1:0] wr_data, int_data, mem_wdata, rd_data;
  logic          mem_we;
  rmode_t        rmode, sel_q;
  logic [7:0]    status;
  logic [7:0]    stat_q;
  logic [DW-1:0] id_q;

  bus_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  wsm_ctrl #(.AW(AW), .DW(DW), .BLK_AW(BLK_AW), .PROG_CYC(PROG_CYC),
             .ERASE_CYC(ERASE_CYC)) u_wsm (
    .clk(clk), .rst(rst), .wr_vld(wr_vld), .wr_addr(wr_addr),
    .wr_data(wr_data), .int_data(int_data), .int_addr(int_addr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .rmode_o(rmode), .status_o(status), .ready_o(ready)
  );

  flash_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rd_addr(addr), .rd_data(rd_data), .int_addr(int_addr),
    .int_data(int_data), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= RM_ARRAY;
      stat_q <= 8'h80;
      id_q   <= '0;
    end else begin
      sel_q  <= rmode;
      stat_q <= status;
      id_q   <= addr[0] ? DEV_ID : MFR_ID;
    end
  end

  always_comb begin
    case (sel_q)
      RM_STATUS: dout = DW'(stat_q);
      RM_IDENT:  dout = id_q;
      default:   dout = rd_data;
    endcase
  end
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  localparam int AW = 6;
  localparam int DW = 8;

  logic clk = 1'b0, rst = 1'b1, ce_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic ready;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  event smp_ev;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.AW(AW), .DW(DW), .BLK_AW(4), .PROG_CYC(20),
                   .ERASE_CYC(60)) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .dout(dout), .ready(ready)
  );

  always @(smp_ev) begin
    logic [DW-1:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    vectors++;
    if (dout !== e) begin
      miscompares++;
      $display("FAIL %s: dout=%h expected %h", t, dout, e);
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic expect_rd(input logic [AW-1:0] a, input logic [DW-1:0] e,
                           input string t);
    @(negedge clk); addr = a;
    @(negedge clk);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    -> smp_ev;
    #1;
  endtask

  task automatic chk_ready(input logic e, input string t);
    vectors++;
    if (ready !== e) begin
      miscompares++;
      $display("FAIL %s: ready=%b expected %b", t, ready, e);
    end
  endtask

  task automatic poll(input string t);
    int n = 0;
    do begin
      @(negedge clk); addr = '0;
      @(negedge clk);
      @(negedge clk);
      n++;
    end while (dout[7] !== 1'b1 && n < 500);
    if (n >= 500) begin
      vectors++;
      miscompares++;
      $display("FAIL %s: status bit7=%b expected 1 (poll timeout)", t, dout[7]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_ready(1'b1, "R1");
    expect_rd(6'd0, 8'hFF, "R1");
    bus_wr(0, 8'h70);
    expect_rd(6'd0, 8'h80, "R1");
    // R9 identifier and array modes
    bus_wr(0, 8'h90);
    expect_rd(6'd0, 8'h5A, "R9");
    expect_rd(6'd1, 8'hC3, "R9");
    bus_wr(0, 8'hFF);
    expect_rd(6'd3, 8'hFF, "R9");
    // R2 program, R4 busy behaviour
    bus_wr(0, 8'h40);
    bus_wr(6'd5, 8'hA5);
    @(negedge clk);
    chk_ready(1'b0, "R4");
    bus_wr(0, 8'hFF);
    expect_rd(6'd5, 8'h00, "R4");
    poll("R2");
    expect_rd(6'd5, 8'h80, "R4");
    bus_wr(0, 8'hFF);
    expect_rd(6'd5, 8'hA5, "R2");
    expect_rd(6'd6, 8'hFF, "R2");
    // R3 AND programming
    bus_wr(0, 8'h10);
    bus_wr(6'd5, 8'h3C);
    poll("R3");
    bus_wr(0, 8'hFF);
    expect_rd(6'd5, 8'h24, "R3");
    bus_wr(0, 8'h40);
    bus_wr(6'h12, 8'h77);
    poll("R2");
    // R5 block erase of block 0
    bus_wr(0, 8'h20);
    bus_wr(6'd3, 8'hD0);
    poll("R5");
    bus_wr(0, 8'hFF);
    expect_rd(6'd5, 8'hFF, "R5");
    expect_rd(6'h12, 8'h77, "R5");
    // R7 bad confirm, R8 clear
    bus_wr(0, 8'h20);
    bus_wr(6'h12, 8'h55);
    expect_rd(6'd0, 8'hB0, "R7");
    chk_ready(1'b1, "R7");
    bus_wr(0, 8'hFF);
    expect_rd(6'h12, 8'h77, "R7");
    bus_wr(0, 8'h70);
    expect_rd(6'd0, 8'hB0, "R8");
    bus_wr(0, 8'h50);
    expect_rd(6'd0, 8'h80, "R8");
    // R13 chip enable rises first, data changes afterwards
    @(negedge clk); addr = 6'd7; din = 8'h40; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); din = 8'h20; we_n = 1'b1;
    @(negedge clk);
    bus_wr(6'd7, 8'h0F);
    poll("R13");
    bus_wr(0, 8'hFF);
    expect_rd(6'd7, 8'h0F, "R13");
    // R12 program suspend and resume
    bus_wr(0, 8'h40);
    bus_wr(6'd9, 8'h81);
    bus_wr(0, 8'hB0);
    @(negedge clk);
    expect_rd(6'd0, 8'h84, "R12");
    chk_ready(1'b1, "R12");
    bus_wr(0, 8'hFF);
    expect_rd(6'd9, 8'hFF, "R12");
    bus_wr(0, 8'hD0);
    expect_rd(6'd0, 8'h00, "R12");
    poll("R12");
    bus_wr(0, 8'hFF);
    expect_rd(6'd9, 8'h81, "R12");
    // R10 erase suspend of block 1
    bus_wr(0, 8'h20);
    bus_wr(6'h10, 8'hD0);
    bus_wr(0, 8'hB0);
    @(negedge clk);
    expect_rd(6'd0, 8'hC0, "R10");
    bus_wr(0, 8'hFF);
    expect_rd(6'h12, 8'h77, "R10");
    bus_wr(0, 8'h20);
    bus_wr(0, 8'h70);
    expect_rd(6'd0, 8'hC0, "R10");
    bus_wr(0, 8'h40);
    bus_wr(6'h25, 8'h3E);
    poll("R10");
    expect_rd(6'd0, 8'hC0, "R10");
    bus_wr(0, 8'hFF);
    expect_rd(6'h25, 8'h3E, "R10");
    // R11 resume
    bus_wr(0, 8'hD0);
    expect_rd(6'd0, 8'h00, "R11");
    chk_ready(1'b0, "R11");
    poll("R11");
    expect_rd(6'd0, 8'h80, "R11");
    bus_wr(0, 8'hFF);
    expect_rd(6'h12, 8'hFF, "R11");
    expect_rd(6'h25, 8'h3E, "R11");
    // R6 full-chip erase
    bus_wr(0, 8'h30);
    bus_wr(0, 8'hD0);
    poll("R6");
    bus_wr(0, 8'hFF);
    expect_rd(6'h25, 8'hFF, "R6");
    expect_rd(6'd9, 8'hFF, "R6");
    expect_rd(6'd7, 8'hFF, "R6");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule